// File: doc/BRIEF.md
# Flag Offset Register Programmer

This block keeps the two threshold offsets used by a FIFO's partial flags: one that measures distance from the empty boundary (the low offset) and one that measures distance from the full boundary (the high offset). It hands both values straight to the flag comparison logic, which sits outside the block. A master reset loads both offsets with a default. The level of the load-qualify input `ld` during that reset picks both the default value and the programming method that stays in force until the next master reset.

After master reset the offsets can be changed in one of two ways. In parallel mode a word on the data bus is taken on each qualified write. In serial mode one bit from a serial input is taken on each qualified shift. In either mode the offsets can be read back in parallel on the output bus. The same `ld` input also qualifies every write, shift and readback, so the ordinary write and read enables go on driving the FIFO array when `ld` is low.

A partial reset leaves the offsets, the method and the sequence positions alone. The whole block works on one clock.

Top module: `ofs_prog_top`

## Requirements
- R1: On a clock edge with `mrs` high, both offsets load 127 and parallel mode is selected if `ld` is 0, or both offsets load 1023 and serial mode is selected if `ld` is 1. `rdData` clears to 0.
- R2: In parallel mode, each edge with `wen` and `ld` both high writes `d[OFS_W-1:0]` to one offset. The writes alternate, low offset first and then high offset, and wrap after the high offset.
- R3: In serial mode, each edge with `sen` and `ld` both high stores `si` at one bit position. Counting the k-th such shift from 0, shifts k = 0..OFS_W-1 set bit k of the low offset, and shifts k = OFS_W..2*OFS_W-1 set bit k-OFS_W of the high offset. After the last bit of the high offset, the next shift goes to bit 0 of the low offset.
- R4: In serial mode `wen` has no effect on the offsets. In parallel mode `sen` has no effect. With `ld` low, no write, shift or readback takes place.
- R5: Each edge with `ren` and `ld` both high loads `rdData` with an offset, zero-extended to DATA_W. The reads alternate, low offset first and then high offset, in either mode. At all other times `rdData` holds its value.
- R6: When a readback and a parallel write fall on the same edge, `rdData` receives the value the selected offset held before that edge.
- R7: While `prs` is high (and `mrs` is low), the offsets, the mode, `rdData` and both sequence positions stay unchanged. The next qualified operation after `prs` continues the sequence where it left off.
- R8: Master reset returns the write sequence, the read sequence and the serial bit position to the low offset, even in the middle of a sequence.
- R9: `mrs` takes precedence: a write, shift or read requested on the same edge as `mrs` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| mrs | input | 1 | Master reset, active high, synchronous |
| prs | input | 1 | Partial reset, active high; freezes this block |
| ld | input | 1 | Picks the default and the method during `mrs`; qualifies operations at other times |
| wen | input | 1 | Write enable for parallel loading |
| sen | input | 1 | Serial enable for bit shifting |
| si | input | 1 | Serial data bit |
| d | input | DATA_W | Parallel data in |
| ren | input | 1 | Read enable for readback |
| aeOfs | output | OFS_W | Offset from the empty boundary |
| afOfs | output | OFS_W | Offset from the full boundary |
| rdData | output | DATA_W | Readback word |

## Verification
A readback and a parallel write can fall on the same edge. This happens when `wen`, `ren` and `ld` are all high together, and the two operations have separate pointers that can point at the same offset register. The bench raises all three on one edge right after master reset, when both pointers point at the low offset. It then expects `rdData` to show the default 127 while the low offset takes the new data word. A second case sets `mrs` together with a write. There the expected outcome is the default value alone, with no trace of the data word.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic loadDef;   // master reset: load defaults, clear bit position
    logic defLarge;  // choose the large default
    logic wrLo;      // parallel write into the low offset
    logic wrHi;      // parallel write into the high offset
    logic shift;     // store one serial bit
    logic rdEn;      // capture readback word
    logic rdHi;      // readback selects the high offset
  } ofsStrobe_t;

endpackage

// File: rtl/ofs_prog_ctrl.sv
module ofs_prog_ctrl
  import ofs_prog_pkg::*;
(
  input  logic       clk,
  input  logic       mrs,
  input  logic       prs,
  input  logic       ld,
  input  logic       wen,
  input  logic       sen,
  input  logic       ren,
  output ofsStrobe_t st
);

  logic serialMode;
  logic wrPtr;
  logic rdPtr;
  logic active;

  always_comb begin
    active      = !mrs && !prs;
    st.loadDef  = mrs;
    st.defLarge = ld;
    st.wrLo     = active && !serialMode && wen && ld && !wrPtr;
    st.wrHi     = active && !serialMode && wen && ld && wrPtr;
    st.shift    = active && serialMode && sen && ld;
    st.rdEn     = active && ren && ld;
    st.rdHi     = rdPtr;
  end

  always_ff @(posedge clk) begin
    if (mrs) begin
      serialMode <= ld;
      wrPtr      <= 1'b0;
      rdPtr      <= 1'b0;
    end else begin
      if (st.wrLo || st.wrHi) wrPtr <= !wrPtr;
      if (st.rdEn)            rdPtr <= !rdPtr;
    end
  end

endmodule

// File: rtl/ofs_prog_dp.sv
module ofs_prog_dp
  import ofs_prog_pkg::*;
#(
  parameter int unsigned OFS_W  = 17,
  parameter int unsigned DATA_W = 18,
  parameter int unsigned DEF_SM = 127,
  parameter int unsigned DEF_LG = 1023
) (
  input  logic              clk,
  input  ofsStrobe_t        st,
  input  logic              si,
  input  logic [DATA_W-1:0] d,
  output logic [OFS_W-1:0]  loOfs,
  output logic [OFS_W-1:0]  hiOfs,
  output logic [DATA_W-1:0] rdData
);

  localparam int unsigned NBITS = 2 * OFS_W;
  localparam int unsigned CNT_W = $clog2(NBITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBITS - 1);

  logic [CNT_W-1:0] bitPos;
  logic [OFS_W-1:0] defVal;
  logic [OFS_W-1:0] rdSel;

  always_comb begin
    defVal = st.defLarge ? OFS_W'(DEF_LG) : OFS_W'(DEF_SM);
    rdSel  = st.rdHi ? hiOfs : loOfs;
  end

  always_ff @(posedge clk) begin
    if (st.loadDef) begin
      loOfs  <= defVal;
      hiOfs  <= defVal;
      bitPos <= '0;
      rdData <= '0;
    end else begin
      if (st.wrLo) loOfs <= d[OFS_W-1:0];
      if (st.wrHi) hiOfs <= d[OFS_W-1:0];
      if (st.shift) begin
        for (int i = 0; i < OFS_W; i++) begin
          if (bitPos == CNT_W'(i))         loOfs[i] <= si;
          if (bitPos == CNT_W'(i + OFS_W)) hiOfs[i] <= si;
        end
        bitPos <= (bitPos == LAST) ? '0 : bitPos + 1'b1;
      end
      if (st.rdEn) rdData <= DATA_W'(rdSel);
    end
  end

endmodule

// File: rtl/ofs_prog_top.sv
module ofs_prog_top
  import ofs_prog_pkg::*;
#(
  parameter int unsigned OFS_W  = 17,
  parameter int unsigned DATA_W = 18,
  parameter int unsigned DEF_SM = 127,
  parameter int unsigned DEF_LG = 1023
) (
  input  logic              clk,
  input  logic              mrs,
  input  logic              prs,
  input  logic              ld,
  input  logic              wen,
  input  logic              sen,
  input  logic              si,
  input  logic [DATA_W-1:0] d,
  input  logic              ren,
  output logic [OFS_W-1:0]  aeOfs,
  output logic [OFS_W-1:0]  afOfs,
  output logic [DATA_W-1:0] rdData
);

  ofsStrobe_t st;

  ofs_prog_ctrl ctrl_i (
    .clk (clk),
    .mrs (mrs),
    .prs (prs),
    .ld  (ld),
    .wen (wen),
    .sen (sen),
    .ren (ren),
    .st  (st)
  );

  ofs_prog_dp #(
    .OFS_W  (OFS_W),
    .DATA_W (DATA_W),
    .DEF_SM (DEF_SM),
    .DEF_LG (DEF_LG)
  ) dp_i (
    .clk    (clk),
    .st     (st),
    .si     (si),
    .d      (d),
    .loOfs  (aeOfs),
    .hiOfs  (afOfs),
    .rdData (rdData)
  );

endmodule

// File: rtl/ofs_prog_chk.sv
module ofs_prog_chk #(
  parameter int unsigned OFS_W  = 17,
  parameter int unsigned DATA_W = 18,
  parameter int unsigned DEF_SM = 127,
  parameter int unsigned DEF_LG = 1023
) (
  input logic              clk,
  input logic              mrs,
  input logic              prs,
  input logic              ld,
  input logic              wen,
  input logic              sen,
  input logic              ren,
  input logic [OFS_W-1:0]  aeOfs,
  input logic [OFS_W-1:0]  afOfs,
  input logic [DATA_W-1:0] rdData
);

  logic armed = 1'b0;
  logic serSeen = 1'b0;

  always_ff @(posedge clk) begin
    if (mrs) begin
      armed   <= 1'b1;
      serSeen <= ld;
    end
  end

  // R1 and R9: defaults after master reset, whatever else was requested
  p_mrs_default_r1: assert property (@(posedge clk) disable iff (!armed)
    mrs |=> (aeOfs == ($past(ld) ? OFS_W'(DEF_LG) : OFS_W'(DEF_SM))) &&
            (afOfs == aeOfs) && (rdData == '0));

  // R4: ld low means nothing moves
  p_ld_gate_r4: assert property (@(posedge clk) disable iff (!armed || mrs)
    !ld |=> $stable(aeOfs) && $stable(afOfs) && $stable(rdData));

  // R4: the enable of the method not selected is ignored
  p_method_excl_r4: assert property (@(posedge clk) disable iff (!armed || mrs)
    ((serSeen && !sen) || (!serSeen && !wen)) |=> $stable(aeOfs) && $stable(afOfs));

  // R5: readback word holds unless a qualified read happens
  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!armed || mrs)
    !(ren && ld) |=> $stable(rdData));

  // R7: partial reset freezes the block
  p_prs_freeze_r7: assert property (@(posedge clk) disable iff (!armed || mrs)
    prs |=> $stable(aeOfs) && $stable(afOfs) && $stable(rdData));

endmodule

bind ofs_prog_top ofs_prog_chk #(
  .OFS_W  (OFS_W),
  .DATA_W (DATA_W),
  .DEF_SM (DEF_SM),
  .DEF_LG (DEF_LG)
) chk_i (
  .clk    (clk),
  .mrs    (mrs),
  .prs    (prs),
  .ld     (ld),
  .wen    (wen),
  .sen    (sen),
  .ren    (ren),
  .aeOfs  (aeOfs),
  .afOfs  (afOfs),
  .rdData (rdData)
);

// File: tb/ofs_prog_tb.sv
module ofs_prog_top_tb_top;

  localparam int OFS_W  = 17;
  localparam int DATA_W = 18;

  logic              clk = 1'b0;
  logic              mrs = 1'b0, prs = 1'b0, ld = 1'b0;
  logic              wen = 1'b0, sen = 1'b0, si = 1'b0, ren = 1'b0;
  logic [DATA_W-1:0] d = '0;
  logic [OFS_W-1:0]  aeOfs, afOfs;
  logic [DATA_W-1:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = !clk;

  ofs_prog_top dut_i (
    .clk(clk), .mrs(mrs), .prs(prs), .ld(ld), .wen(wen), .sen(sen),
    .si(si), .d(d), .ren(ren), .aeOfs(aeOfs), .afOfs(afOfs), .rdData(rdData)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idleIn();
    mrs = 0; prs = 0; ld = 0; wen = 0; sen = 0; si = 0; ren = 0; d = '0;
  endtask

  // apply current inputs for one edge, then sample just after it
  task automatic step();
    @(posedge clk); #1;
    idleIn();
  endtask

  task automatic doMrs(input logic ldv);
    idleIn(); mrs = 1; ld = ldv; step();
  endtask

  task automatic parWrite(input int v);
    idleIn(); wen = 1; ld = 1; d = DATA_W'(v); step();
  endtask

  task automatic readOne();
    idleIn(); ren = 1; ld = 1; step();
  endtask

  task automatic shiftBits(input logic [2*OFS_W-1:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      idleIn(); sen = 1; ld = 1; si = bits[i]; step();
    end
  endtask

  task automatic t_reset();
    doMrs(1'b0);
    check("R1 small default lo", int'(aeOfs), 127);
    check("R1 small default hi", int'(afOfs), 127);
    check("R1 rdData cleared", int'(rdData), 0);
    doMrs(1'b1);
    check("R1 large default lo", int'(aeOfs), 1023);
    check("R1 large default hi", int'(afOfs), 1023);
  endtask

  task automatic t_parallel();
    doMrs(1'b0);
    parWrite(5);
    check("R2 first write lo", int'(aeOfs), 5);
    check("R2 first write hi untouched", int'(afOfs), 127);
    parWrite(9);
    check("R2 second write hi", int'(afOfs), 9);
    parWrite(11);
    check("R2 wrap to lo", int'(aeOfs), 11);
    check("R2 wrap hi kept", int'(afOfs), 9);
    readOne();
    check("R5 read lo", int'(rdData), 11);
    readOne();
    check("R5 read hi", int'(rdData), 9);
    idleIn(); ren = 1; step();
    check("R4 ren without ld holds", int'(rdData), 9);
    readOne();
    check("R5 read wraps lo", int'(rdData), 11);
    idleIn(); sen = 1; ld = 1; si = 1; step();
    check("R4 sen ignored parallel lo", int'(aeOfs), 11);
    check("R4 sen ignored parallel hi", int'(afOfs), 9);
    idleIn(); wen = 1; d = 18'd77; step();
    check("R4 wen without ld lo", int'(aeOfs), 11);
    check("R4 wen without ld hi", int'(afOfs), 9);
  endtask

  task automatic t_same_cycle();
    doMrs(1'b0);
    idleIn(); wen = 1; ren = 1; ld = 1; d = 18'd33; step();
    check("R6 read sees old value", int'(rdData), 127);
    check("R6 write landed", int'(aeOfs), 33);
  endtask

  task automatic t_prs();
    doMrs(1'b0);
    parWrite(20);
    idleIn(); prs = 1; wen = 1; ren = 1; ld = 1; d = 18'd44; step();
    check("R7 prs hi kept", int'(afOfs), 127);
    check("R7 prs lo kept", int'(aeOfs), 20);
    check("R7 prs no read", int'(rdData), 0);
    parWrite(21);
    check("R7 sequence resumes hi", int'(afOfs), 21);
    readOne();
    check("R7 read sequence resumes lo", int'(rdData), 20);
  endtask

  task automatic t_serial();
    logic [OFS_W-1:0] a, b;
    a = 17'h15A5C; b = 17'h0B0B1;
    doMrs(1'b1);
    shiftBits({b, a}, OFS_W);
    check("R3 lo after first half", int'(aeOfs), int'(a));
    check("R3 hi untouched first half", int'(afOfs), 1023);
    shiftBits({a, b}, OFS_W);
    check("R3 hi filled", int'(afOfs), int'(b));
    check("R3 lo kept", int'(aeOfs), int'(a));
    shiftBits('1, 1);
    check("R3 wrap to lo bit0", int'(aeOfs), int'(a | 17'h1));
    parWrite(3);
    check("R4 wen ignored serial lo", int'(aeOfs), int'(a | 17'h1));
    check("R4 wen ignored serial hi", int'(afOfs), int'(b));
    readOne();
    check("R5 serial read lo", int'(rdData), int'(a | 17'h1));
    readOne();
    check("R5 serial read hi", int'(rdData), int'(b));
  endtask

  task automatic t_mrs_mid();
    doMrs(1'b0);
    parWrite(6);
    readOne();
    doMrs(1'b0);
    parWrite(7);
    check("R8 write ptr back to lo", int'(aeOfs), 7);
    check("R8 hi default", int'(afOfs), 127);
    readOne();
    check("R8 read ptr back to lo", int'(rdData), 7);
    doMrs(1'b1);
    shiftBits('1, 3);
    doMrs(1'b1);
    shiftBits('0, 1);
    check("R8 serial pos back to bit0", int'(aeOfs), 1022);
  endtask

  task automatic t_mrs_prio();
    idleIn(); mrs = 1; wen = 1; ren = 1; ld = 0; d = 18'd55; step();
    idleIn(); mrs = 1; wen = 1; ren = 1; ld = 1; sen = 1; si = 0; d = 18'd55; step();
    check("R9 mrs beats write lo", int'(aeOfs), 1023);
    check("R9 mrs beats write hi", int'(afOfs), 1023);
    check("R9 mrs beats read", int'(rdData), 0);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    idleIn();
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_parallel();
    t_same_cycle();
    t_prs();
    t_serial();
    t_mrs_mid();
    t_mrs_prio();
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

endmodule